// File: doc/BRIEF.md
# Precise Exception Status Pipeline

This block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) together with a small status record. A record holds a valid bit, the program counter and one cause code. A stage can report a fault for the instruction it holds. The fault is written into that instruction's record, and the record moves forward with the instruction. Nothing acts on the record until the instruction reaches the writeback stage. That stage is the single commit point. Because faults are resolved in one place, they are taken in program order. An older instruction whose fault appears late, in the memory stage, still wins over a younger instruction whose fault appeared earlier, in fetch.

When a faulting instruction reaches writeback, the block raises a trap with the stored cause and the instruction's PC. In the same cycle it flushes every younger instruction to a bubble. It also gates the register-file write enable in writeback and the data-memory write enable in the memory stage. An instruction with a recorded fault never updates state. A sticky kill flag is set at the trap and blocks all writes until the next instruction is accepted into fetch. The fault sources themselves are inputs: translation and protection checks are outside this block.

Top module: `precise_exc_pipe`

## Requirements
- R1: After reset, trap, flush, wb_commit, rf_wen and dmem_wen are all 0.
- R2: A fault-free instruction accepted at cycle n gives wb_commit=1 and wb_pc equal to its PC in cycle n+5. In that cycle rf_wen follows rf_wen_req. In cycle n+4 dmem_wen follows dmem_wen_req. With no instruction in writeback, rf_wen stays 0.
- R3: Fetch faults are encoded from if_fault as follows: if_fault=1 gives cause 1 (fetch page fault), 2 gives cause 2 (fetch misaligned), 3 gives cause 3 (fetch protection). if_fault=0 means no fault.
- R4: id_illegal=1 in decode gives cause 4 (illegal opcode). ex_arith=1 in execute gives cause 5 (arithmetic).
- R5: Memory faults are encoded from mem_fault as follows: mem_fault=1 gives cause 6 (data page fault), 2 gives cause 7 (data misaligned), 3 gives cause 8 (data protection).
- R6: A faulting instruction accepted at cycle n raises trap only in cycle n+5, and never in cycles n+1 to n+4. In that cycle trap_cause is its cause, trap_pc is its PC and flush is 1.
- R7: When one instruction reports faults in more than one stage, the cause from the earliest of those stages is the one trapped.
- R8: An older instruction's memory-stage fault is trapped even if a younger instruction reported a fetch fault in an earlier cycle. The younger fault is never trapped.
- R9: In the trap cycle, every younger instruction and the instruction offered at in_valid are dropped. None of them commits or writes.
- R10: An instruction with a recorded fault never asserts rf_wen. It also never asserts dmem_wen once its fault is recorded by or raised in the memory stage.
- R11: From the trap onward, rf_wen and dmem_wen stay 0 until a new instruction is accepted. That instruction commits and writes normally.
- R12: Fault inputs for a stage that holds no instruction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction enters fetch this cycle |
| in_pc | input | PC_W | PC of the entering instruction |
| if_fault | input | 2 | Fetch-stage fault kind (0 = none) |
| id_illegal | input | 1 | Decode-stage illegal opcode |
| ex_arith | input | 1 | Execute-stage arithmetic fault |
| mem_fault | input | 2 | Memory-stage fault kind (0 = none) |
| rf_wen_req | input | 1 | Writeback instruction wants a register write |
| dmem_wen_req | input | 1 | Memory-stage instruction wants a store |
| rf_wen | output | 1 | Gated register-file write enable |
| dmem_wen | output | 1 | Gated data-memory write enable |
| wb_commit | output | 1 | Writeback instruction retires without fault |
| wb_pc | output | PC_W | PC of the writeback instruction |
| trap | output | 1 | Exception taken this cycle |
| trap_cause | output | 4 | Cause code of the taken exception |
| trap_pc | output | PC_W | PC of the faulting instruction |
| flush | output | 1 | Younger instructions are being squashed |

## Verification
The bound checker watches several properties on every cycle. After a trap the upper pipeline slots are empty, no write or commit follows, and no second trap follows. A trap only comes from an instruction that moved up from the memory stage. A fault raised on a live memory-stage instruction always blocks the store in that cycle. Other behaviours need the bench's ordered stimulus: the cause encodings, the earliest-stage choice between two faults of one instruction, and the older-instruction-wins ordering. The same holds for the exact trap cycle, the release of the kill flag by the next accepted instruction, and the inputs ignored on empty stages.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_STAGES   = 5;
  localparam int COMMIT_IDX   = NUM_STAGES - 1;
  localparam int NUM_REPORTING = NUM_STAGES - 1;
  localparam int MEM_IDX      = NUM_STAGES - 2;
  localparam int CAUSE_W      = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 4'd0,
    CAUSE_IPAGE   = 4'd1,
    CAUSE_IMISAL  = 4'd2,
    CAUSE_IPROT   = 4'd3,
    CAUSE_ILLEGAL = 4'd4,
    CAUSE_ARITH   = 4'd5,
    CAUSE_DPAGE   = 4'd6,
    CAUSE_DMISAL  = 4'd7,
    CAUSE_DPROT   = 4'd8
  } cause_e;

  localparam logic [CAUSE_W-1:0] MEM_CAUSE_BASE = 4'd5;
endpackage

// File: rtl/exc_cause_map.sv
module exc_cause_map
  import exc_pkg::*;
(
  input  logic [NUM_REPORTING-1:0] stage_vld_i,
  input  logic [1:0]               if_fault_i,
  input  logic                     id_illegal_i,
  input  logic                     ex_arith_i,
  input  logic [1:0]               mem_fault_i,
  output cause_e                   raised_o [NUM_REPORTING]
);
  cause_e raw [NUM_REPORTING];

  always_comb begin
    raw[0] = (if_fault_i == 2'd0) ? CAUSE_NONE : cause_e'({2'b00, if_fault_i});
    raw[1] = id_illegal_i ? CAUSE_ILLEGAL : CAUSE_NONE;
    raw[2] = ex_arith_i ? CAUSE_ARITH : CAUSE_NONE;
    raw[MEM_IDX] = (mem_fault_i == 2'd0) ? CAUSE_NONE
                 : cause_e'({2'b00, mem_fault_i} + MEM_CAUSE_BASE);
  end

  // An empty stage cannot raise anything (R12)
  for (genvar k = 0; k < NUM_REPORTING; k++) begin : g_gate
    assign raised_o[k] = stage_vld_i[k] ? raw[k] : CAUSE_NONE;
  end
endmodule

// File: rtl/exc_slot.sv
module exc_slot
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            vld_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          cause_i,
  output logic            vld_o,
  output logic [PC_W-1:0] pc_o,
  output cause_e          cause_o
);
  logic            vld_d, vld_q;
  logic            load_en;
  logic [PC_W-1:0] pc_q;
  cause_e          cause_q;

  always_comb begin
    vld_d   = vld_i && !flush_i;
    load_en = vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      pc_q    <= pc_i;
      cause_q <= cause_i;
    end
  end

  assign vld_o   = vld_q;
  assign pc_o    = pc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid_i,
  input  logic            wb_vld_i,
  input  logic [PC_W-1:0] wb_pc_i,
  input  cause_e          wb_cause_i,
  input  logic            mem_vld_i,
  input  cause_e          mem_cause_i,
  input  logic            rf_wen_req_i,
  input  logic            dmem_wen_req_i,
  output logic            trap_o,
  output logic [CAUSE_W-1:0] trap_cause_o,
  output logic [PC_W-1:0] trap_pc_o,
  output logic            wb_commit_o,
  output logic            rf_wen_o,
  output logic            dmem_wen_o,
  output logic            kill_o
);
  logic kill_q, kill_d, kill_en;
  logic trap;

  always_comb begin
    trap         = wb_vld_i && (wb_cause_i != CAUSE_NONE) && !kill_q;
    wb_commit_o  = wb_vld_i && (wb_cause_i == CAUSE_NONE) && !kill_q;
    rf_wen_o     = rf_wen_req_i && wb_commit_o;
    dmem_wen_o   = dmem_wen_req_i && mem_vld_i && (mem_cause_i == CAUSE_NONE)
                   && !trap && !kill_q;
    trap_cause_o = trap ? wb_cause_i : CAUSE_NONE;
    trap_pc_o    = trap ? wb_pc_i : '0;
    // set on trap, cleared by the next accepted instruction (R11)
    kill_en      = trap || in_valid_i;
    kill_d       = trap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kill_q <= 1'b0;
    else if (kill_en) kill_q <= kill_d;
  end

  assign trap_o = trap;
  assign kill_o = kill_q;
endmodule

// File: rtl/precise_exc_pipe.sv
module precise_exc_pipe
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  logic [1:0]      if_fault,
  input  logic            id_illegal,
  input  logic            ex_arith,
  input  logic [1:0]      mem_fault,
  input  logic            rf_wen_req,
  input  logic            dmem_wen_req,
  output logic            rf_wen,
  output logic            dmem_wen,
  output logic            wb_commit,
  output logic [PC_W-1:0] wb_pc,
  output logic            trap,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [PC_W-1:0] trap_pc,
  output logic            flush
);
  logic                    slot_vld   [NUM_STAGES];
  logic [PC_W-1:0]         slot_pc    [NUM_STAGES];
  cause_e                  slot_cause [NUM_STAGES];
  cause_e                  merged     [NUM_REPORTING];
  cause_e                  raised     [NUM_REPORTING];
  logic [NUM_STAGES-1:0]   stage_vld;
  logic                    kill_flag;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_vld
    assign stage_vld[k] = slot_vld[k];
  end

  exc_cause_map u_map (
    .stage_vld_i  (stage_vld[NUM_REPORTING-1:0]),
    .if_fault_i   (if_fault),
    .id_illegal_i (id_illegal),
    .ex_arith_i   (ex_arith),
    .mem_fault_i  (mem_fault),
    .raised_o     (raised)
  );

  // First recorded cause sticks: the earliest stage wins (R7)
  for (genvar k = 0; k < NUM_REPORTING; k++) begin : g_merge
    assign merged[k] = !slot_vld[k]                 ? CAUSE_NONE :
                       (slot_cause[k] != CAUSE_NONE) ? slot_cause[k] : raised[k];
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_slot
    if (k == 0) begin : g_entry
      exc_slot #(.PC_W(PC_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .vld_i(in_valid), .pc_i(in_pc), .cause_i(CAUSE_NONE),
        .vld_o(slot_vld[k]), .pc_o(slot_pc[k]), .cause_o(slot_cause[k])
      );
    end else begin : g_follow
      exc_slot #(.PC_W(PC_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .vld_i(slot_vld[k-1]), .pc_i(slot_pc[k-1]), .cause_i(merged[k-1]),
        .vld_o(slot_vld[k]), .pc_o(slot_pc[k]), .cause_o(slot_cause[k])
      );
    end
  end

  exc_commit #(.PC_W(PC_W)) u_commit (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid_i     (in_valid),
    .wb_vld_i       (slot_vld[COMMIT_IDX]),
    .wb_pc_i        (slot_pc[COMMIT_IDX]),
    .wb_cause_i     (slot_cause[COMMIT_IDX]),
    .mem_vld_i      (slot_vld[MEM_IDX]),
    .mem_cause_i    (merged[MEM_IDX]),
    .rf_wen_req_i   (rf_wen_req),
    .dmem_wen_req_i (dmem_wen_req),
    .trap_o         (trap),
    .trap_cause_o   (trap_cause),
    .trap_pc_o      (trap_pc),
    .wb_commit_o    (wb_commit),
    .rf_wen_o       (rf_wen),
    .dmem_wen_o     (dmem_wen),
    .kill_o         (kill_flag)
  );

  assign flush = trap;
  assign wb_pc = slot_pc[COMMIT_IDX];
endmodule

// File: rtl/exc_checker.sv
module exc_checker
  import exc_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trap,
  input logic                  rf_wen,
  input logic                  dmem_wen,
  input logic                  wb_commit,
  input logic [1:0]            mem_fault,
  input logic [NUM_STAGES-1:0] stage_vld,
  input logic                  kill_flag
);
  // R6: a trap only comes from an instruction that just left the memory stage
  a_r6_trap_from_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(stage_vld[MEM_IDX]));

  // R9: the flush leaves the downstream slots empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (stage_vld[NUM_STAGES-1:1] == '0));

  // R9: nothing commits or writes the cycle after a trap
  a_r9_no_write_after: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (!rf_wen && !dmem_wen && !wb_commit));

  // R8: one trap per fault, the younger ones are gone
  a_r8_single_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);

  // R11: the kill flag is in force after a trap
  a_r11_kill_set: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> kill_flag);

  // R10: a memory fault on a live memory-stage instruction blocks its store
  a_r10_mem_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_vld[MEM_IDX] && (mem_fault != 2'd0)) |-> !dmem_wen);
endmodule

bind precise_exc_pipe exc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trap      (trap),
  .rf_wen    (rf_wen),
  .dmem_wen  (dmem_wen),
  .wb_commit (wb_commit),
  .mem_fault (mem_fault),
  .stage_vld (stage_vld),
  .kill_flag (kill_flag)
);

// File: tb/tb_precise_exc_pipe.sv
module tb_precise_exc_pipe;
  localparam int PC_W = 32;
  localparam int NC   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid, id_illegal, ex_arith, rf_wen_req, dmem_wen_req;
  logic [PC_W-1:0] in_pc;
  logic [1:0] if_fault, mem_fault;
  logic rf_wen, dmem_wen, wb_commit, trap, flush;
  logic [PC_W-1:0] wb_pc, trap_pc;
  logic [3:0] trap_cause;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // stimulus per cycle
  logic            sv [NC];
  logic [PC_W-1:0] spc [NC];
  logic [1:0]      sif [NC];
  logic            sid [NC];
  logic            sex [NC];
  logic [1:0]      smem [NC];
  logic            srf [NC];
  logic            sdm [NC];
  // observations per cycle
  logic            otrap [NC];
  logic [3:0]      ocause [NC];
  logic [PC_W-1:0] otpc [NC];
  logic            orf [NC];
  logic            odm [NC];
  logic            ocom [NC];
  logic [PC_W-1:0] owpc [NC];
  logic            oflush [NC];

  always #10 clk = ~clk;

  precise_exc_pipe #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .if_fault(if_fault), .id_illegal(id_illegal), .ex_arith(ex_arith),
    .mem_fault(mem_fault), .rf_wen_req(rf_wen_req), .dmem_wen_req(dmem_wen_req),
    .rf_wen(rf_wen), .dmem_wen(dmem_wen), .wb_commit(wb_commit), .wb_pc(wb_pc),
    .trap(trap), .trap_cause(trap_cause), .trap_pc(trap_pc), .flush(flush)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int c = 0; c < NC; c++) begin
      sv[c] = 0; spc[c] = '0; sif[c] = 0; sid[c] = 0;
      sex[c] = 0; smem[c] = 0; srf[c] = 0; sdm[c] = 0;
    end
  endtask

  task automatic drive_idle();
    in_valid = 0; in_pc = '0; if_fault = 0; id_illegal = 0;
    ex_arith = 0; mem_fault = 0; rf_wen_req = 0; dmem_wen_req = 0;
  endtask

  task automatic run();
    @(negedge clk);
    rst_n = 0;
    drive_idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < NC; c++) begin
      in_valid = sv[c]; in_pc = spc[c]; if_fault = sif[c]; id_illegal = sid[c];
      ex_arith = sex[c]; mem_fault = smem[c]; rf_wen_req = srf[c]; dmem_wen_req = sdm[c];
      #5;
      otrap[c] = trap; ocause[c] = trap_cause; otpc[c] = trap_pc; orf[c] = rf_wen;
      odm[c] = dmem_wen; ocom[c] = wb_commit; owpc[c] = wb_pc; oflush[c] = flush;
      @(negedge clk);
    end
    drive_idle();
  endtask

  function automatic string stage_tag(int k);
    if (k == 0) return "R3";
    if (k < 3) return "R4";
    return "R5";
  endfunction

  function automatic int expect_cause(int k, int code);
    case (k)
      0: return code;
      1: return 4;
      2: return 5;
      default: return 5 + code;
    endcase
  endfunction

  task automatic set_fault(int k, int c, int code);
    case (k)
      0: sif[c] = 2'(code);
      1: sid[c] = 1'b1;
      2: sex[c] = 1'b1;
      default: smem[c] = 2'(code);
    endcase
  endtask

  initial begin
    drive_idle();
    // R1: reset state
    clear_stim();
    run();
    check("R1 trap", otrap[0], 0);
    check("R1 flush", oflush[0], 0);
    check("R1 commit", ocom[0], 0);
    check("R1 rf_wen", orf[0], 0);
    check("R1 dmem_wen", odm[0], 0);

    // R2: clean instructions
    clear_stim();
    for (int i = 0; i < 3; i++) begin
      sv[i] = 1; spc[i] = 32'h40 + 32'(4 * i);
      srf[i + 5] = 1; sdm[i + 4] = 1;
    end
    srf[8] = 1;
    run();
    for (int i = 0; i < 3; i++) begin
      check("R2 commit", ocom[i + 5], 1);
      check("R2 wb_pc", owpc[i + 5], 32'h40 + 32'(4 * i));
      check("R2 rf_wen", orf[i + 5], 1);
      check("R2 dmem_wen", odm[i + 4], 1);
    end
    check("R2 rf_wen empty", orf[8], 0);
    for (int c = 0; c < NC; c++) check("R2 no trap", otrap[c], 0);

    // R3 R4 R5 R6 R10: every stage and code alone
    for (int k = 0; k < 4; k++) begin
      int ncodes = (k == 0 || k == 3) ? 3 : 1;
      for (int code = 1; code <= ncodes; code++) begin
        logic [31:0] pc;
        pc = 32'h100 + 32'(16 * k + code);
        clear_stim();
        sv[0] = 1; spc[0] = pc;
        set_fault(k, 1 + k, code);
        srf[5] = 1; sdm[4] = 1;
        run();
        for (int c = 1; c < 5; c++) check("R6 early trap", otrap[c], 0);
        check("R6 trap", otrap[5], 1);
        check(stage_tag(k), ocause[5], 32'(expect_cause(k, code)));
        check("R6 trap_pc", otpc[5], pc);
        check("R6 flush", oflush[5], 1);
        check("R10 rf_wen", orf[5], 0);
        check("R10 commit", ocom[5], 0);
        check("R10 dmem_wen", odm[4], 0);
        check("R6 after", otrap[6], 0);
      end
    end

    // R7: two faults on one instruction, earliest stage kept
    for (int a = 0; a < 4; a++) begin
      for (int b = a + 1; b < 4; b++) begin
        clear_stim();
        sv[0] = 1; spc[0] = 32'h500;
        set_fault(a, 1 + a, 2);
        set_fault(b, 1 + b, 3);
        run();
        check("R7 trap", otrap[5], 1);
        check("R7 cause", ocause[5], 32'(expect_cause(a, 2)));
      end
    end

    // R8: older memory fault beats younger earlier fetch fault
    clear_stim();
    sv[0] = 1; spc[0] = 32'hA0;
    sv[2] = 1; spc[2] = 32'hB0;
    sif[3] = 2'd1;
    smem[4] = 2'd1;
    run();
    check("R8 trap", otrap[5], 1);
    check("R8 cause", ocause[5], 6);
    check("R8 pc", otpc[5], 32'hA0);
    for (int c = 6; c < NC; c++) check("R8 younger dropped", otrap[c], 0);

    // R9 R10 R11: flush, kill and recovery
    clear_stim();
    for (int i = 0; i < 6; i++) begin sv[i] = 1; spc[i] = 32'h200 + 32'(i); end
    sid[2] = 1;
    sv[8] = 1; spc[8] = 32'h2F0;
    for (int c = 0; c < NC; c++) begin srf[c] = 1; sdm[c] = 1; end
    run();
    check("R9 trap", otrap[5], 1);
    check("R9 cause", ocause[5], 4);
    check("R9 pc", otpc[5], 32'h200);
    check("R10 dmem faulted", odm[4], 0);
    check("R9 dmem younger", odm[5], 0);
    check("R10 rf faulted", orf[5], 0);
    for (int c = 6; c < 12; c++) check("R11 dmem killed", odm[c], 0);
    for (int c = 6; c < 13; c++) begin
      check("R9 rf dropped", orf[c], 0);
      check("R9 commit dropped", ocom[c], 0);
      check("R9 no trap", otrap[c], 0);
    end
    check("R11 dmem resumes", odm[12], 1);
    check("R11 commit resumes", ocom[13], 1);
    check("R11 rf resumes", orf[13], 1);
    check("R11 wb_pc", owpc[13], 32'h2F0);

    // R12: faults on empty stages
    clear_stim();
    for (int c = 0; c < 10; c++) begin
      sif[c] = 2'd3; sid[c] = 1; sex[c] = 1; smem[c] = 2'd2;
    end
    run();
    for (int c = 0; c < NC; c++) check("R12 empty pipe", otrap[c], 0);
    clear_stim();
    sv[0] = 1; spc[0] = 32'h300;
    sif[2] = 2'd1; sif[3] = 2'd2; sid[1] = 1; sex[4] = 1;
    smem[1] = 2'd1; smem[2] = 2'd2; smem[3] = 2'd3;
    srf[5] = 1; sdm[4] = 1;
    run();
    for (int c = 0; c < NC; c++) check("R12 no trap", otrap[c], 0);
    check("R12 commit", ocom[5], 1);
    check("R12 rf_wen", orf[5], 1);
    check("R12 dmem_wen", odm[4], 1);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule